// File: doc/BRIEF.md
# Folded-Pair Pipelined FIR Filter Core

This block is a finite impulse response filter whose coefficient set is mirror-symmetric (or mirror-antisymmetric) about its middle tap. It exploits that symmetry by first combining each pair of samples that share a coefficient value, then multiplying the combined value once. A filter of T taps therefore needs only ceil(T/2) multipliers.

The multiply results are summed along a chain of registered adders. Each link in the chain sees its sample pair one cycle later than the link before it, so no wide adder tree is needed and the critical path stays at one add. Both even and odd tap counts are supported. A build-time flag switches the pair combination from a sum to a difference, which is the form used for high-pass, differentiator and Hilbert-type responses.

A clock enable gates every register. The result leaves at full precision, with FW fractional bits inherited from the coefficients, so that a separate rounding and limiting stage can follow.

Top module: `sym_fir_core`

## Requirements
- R1: With an odd tap count T=N+1, `acc_out` equals the sum over k=0..N of h_k·x[n−k] with h_k = h_(N−k), where x[n] is the n-th sample accepted.
- R2: With an even tap count, `acc_out` follows the same equation with h_k = h_(N−k).
- R3: With `ANTI_SYM`=1, the mirrored half uses h_k = −h_(N−k), so each sample pair is subtracted (near minus far) before its multiply.
- R4: With an odd tap count, the middle coefficient h_(N/2) multiplies its single sample with no pair combination.
- R5: A sample accepted on enabled edge e appears in `acc_out` after enabled edge e+L, where L = T/2+4 for even T and (T−1)/2+6 for odd T.
- R6: While `en` is low, `x_in` is ignored and every register holds its value, so `acc_out` is stable and latency is counted in enabled edges only.
- R7: A clock edge with `rst_n` low clears all sample history and partial sums, and `acc_out` reads zero on the following cycle.
- R8: With `SKIP_ZERO`=1, a zero-valued coefficient builds no multiplier, and the result is identical to the full equation.
- R9: `acc_out` is DW+CW+ceil(log2 T) bits wide, and no input sequence overflows it, including sustained full-scale inputs of either sign.
- R10: Coefficient h_k, for k = 0..ceil(T/2)−1, sits in `COEFS` bits [k·CW +: CW] as a two's-complement value. Legal builds require T>2, CW≥2 and FW<CW.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Clock enable; a sample is taken on an edge where it is high |
| x_in | input | DW | Signed input sample |
| acc_out | output | DW+CW+ceil(log2 TAPS) | Signed full-precision filter result |

## Verification
Every output depends on exactly L enabled edges of history: 9 for the default seven-tap build and 7 for the six-tap antisymmetric build. The bench's reference model therefore keeps a queue that is L results deep and advances it only on edges where `en` is high. An impulse shows each coefficient emerging on its own edge and nowhere else. Outputs are sampled on the falling edge, so each compare sees the value registered at the preceding enabled edge. Gaps in `en` must leave the queue untouched while the output stays frozen.

// File: rtl/sym_fir_pkg.sv
package sym_fir_pkg;

  // number of multiply/accumulate links: one per coefficient pair plus a lone middle tap
  function automatic int n_links(input int taps);
    return (taps + 1) / 2;
  endfunction

  // trailing register stages after the chain so the total latency meets the target
  function automatic int pad_depth(input int taps);
    return (taps % 2 != 0) ? 3 : 2;
  endfunction

  // enabled edges from taking a sample to its result on the output
  function automatic int total_latency(input int taps);
    return (taps % 2 != 0) ? (taps - 1) / 2 + 6 : taps / 2 + 4;
  endfunction

  function automatic int acc_width(input int dw, input int cw, input int taps);
    return dw + cw + $clog2(taps);
  endfunction

endpackage

// File: rtl/sym_fir_delay.sv
module sym_fir_delay #(
  parameter int DW    = 8,
  parameter int DEPTH = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [DW-1:0]       din,
  output logic [DEPTH*DW-1:0] taps
);
  logic [DW-1:0] sr [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) sr[i] <= '0;
    end else if (en) begin
      sr[0] <= din;
      for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_out
    assign taps[g*DW +: DW] = sr[g];
  end
endmodule

// File: rtl/sym_fir_link.sv
module sym_fir_link #(
  parameter int               DW     = 8,
  parameter int               CW     = 8,
  parameter int               AW     = 19,
  parameter logic [CW-1:0]    COEF   = '0,
  parameter bit               PAIRED = 1'b1,
  parameter bit               ANTI   = 1'b0,
  parameter bit               SKIP   = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [DW-1:0] near_s,
  input  logic signed [DW-1:0] far_s,
  input  logic signed [AW-1:0] acc_in,
  output logic signed [AW-1:0] acc_out
);
  localparam int PW = DW + 1 + CW;

  // pair combination: sum, difference, or the lone middle sample
  function automatic logic signed [DW:0] fold(input logic signed [DW-1:0] a,
                                               input logic signed [DW-1:0] b);
    logic signed [DW:0] ea, eb;
    ea = {a[DW-1], a};
    eb = {b[DW-1], b};
    if (!PAIRED) return ea;
    return ANTI ? (ea - eb) : (ea + eb);
  endfunction

  function automatic logic signed [AW-1:0] widen(input logic signed [PW-1:0] p);
    return {{(AW-PW){p[PW-1]}}, p};
  endfunction

  logic signed [AW-1:0] acc_q;
  assign acc_out = acc_q;

  if (SKIP && (COEF == '0)) begin : g_zero
    always_ff @(posedge clk) begin
      if (!rst_n)   acc_q <= '0;
      else if (en)  acc_q <= acc_in;
    end
  end else begin : g_mac
    localparam logic signed [CW-1:0] H = COEF;
    logic signed [DW:0]   pre_q;
    logic signed [PW-1:0] prod_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pre_q  <= '0;
        prod_q <= '0;
        acc_q  <= '0;
      end else if (en) begin
        pre_q  <= fold(near_s, far_s);
        prod_q <= pre_q * H;
        acc_q  <= acc_in + widen(prod_q);
      end
    end
  end
endmodule

// File: rtl/sym_fir_pad.sv
module sym_fir_pad #(
  parameter int W     = 19,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] st [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) st[i] <= '0;
    end else if (en) begin
      st[0] <= din;
      for (int i = 1; i < DEPTH; i++) st[i] <= st[i-1];
    end
  end

  assign dout = st[DEPTH-1];
endmodule

// File: rtl/sym_fir_core.sv
module sym_fir_core
  import sym_fir_pkg::*;
#(
  parameter int TAPS      = 7,
  parameter int DW        = 8,
  parameter int CW        = 8,
  parameter int FW        = 6,
  parameter bit ANTI_SYM  = 1'b0,
  parameter bit SKIP_ZERO = 1'b1,
  parameter logic [((TAPS+1)/2)*CW-1:0] COEFS = {8'd40, 8'd0, 8'hFB, 8'd3}
) (
  input  logic                                           clk,
  input  logic                                           rst_n,
  input  logic                                           en,
  input  logic signed [DW-1:0]                           x_in,
  output logic signed [acc_width(DW, CW, TAPS)-1:0]      acc_out
);
  localparam int  K    = n_links(TAPS);
  localparam int  NI   = TAPS - 1;
  localparam int  AW   = acc_width(DW, CW, TAPS);
  localparam int  PAD  = pad_depth(TAPS);
  localparam bit  ODD  = (TAPS % 2) != 0;

  // sample history: slot i holds the sample taken i enabled edges ago
  logic [TAPS*DW-1:0] hist;
  sym_fir_delay #(.DW(DW), .DEPTH(TAPS)) u_delay (
    .clk(clk), .rst_n(rst_n), .en(en), .din(x_in), .taps(hist)
  );

  // event wires brought out for the checker
  logic signed [DW-1:0] newest_tap;
  logic signed [AW-1:0] pipe_end;
  assign newest_tap = hist[DW-1:0];

  logic signed [AW-1:0] chain [K+1];
  assign chain[0] = '0;

  // link k sees slots 2k and N, which line up the pair (k, N-k) for one output
  for (genvar k = 0; k < K; k++) begin : g_link
    localparam bit LONE = ODD && (k == K - 1);
    sym_fir_link #(
      .DW(DW), .CW(CW), .AW(AW),
      .COEF(COEFS[k*CW +: CW]),
      .PAIRED(!LONE), .ANTI(ANTI_SYM), .SKIP(SKIP_ZERO)
    ) u_link (
      .clk(clk), .rst_n(rst_n), .en(en),
      .near_s(hist[(2*k)*DW +: DW]),
      .far_s(hist[NI*DW +: DW]),
      .acc_in(chain[k]),
      .acc_out(chain[k+1])
    );
  end

  assign pipe_end = chain[K];

  sym_fir_pad #(.W(AW), .DEPTH(PAD)) u_pad (
    .clk(clk), .rst_n(rst_n), .en(en), .din(pipe_end), .dout(acc_out)
  );
endmodule

// File: rtl/sym_fir_chk.sv
module sym_fir_chk #(
  parameter int TAPS = 7,
  parameter int DW   = 8,
  parameter int CW   = 8,
  parameter int FW   = 6,
  parameter int AW   = 19
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 en,
  input logic signed [DW-1:0] x_in,
  input logic signed [AW-1:0] acc_out,
  input logic signed [DW-1:0] newest_tap,
  input logic signed [AW-1:0] pipe_end
);
  // R10
  initial begin
    legal_build_chk: assert (TAPS > 2 && CW >= 2 && FW < CW)
      else $error("illegal build parameters");
  end

  // R6
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc_out));

  // R6
  idle_ignores_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(newest_tap));

  // R6
  sample_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> newest_tap == $past(x_in));

  // R6
  chain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(pipe_end));

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (acc_out == '0 && newest_tap == '0));
endmodule

bind sym_fir_core sym_fir_chk #(
  .TAPS(TAPS), .DW(DW), .CW(CW), .FW(FW), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .x_in(x_in), .acc_out(acc_out),
  .newest_tap(newest_tap), .pipe_end(pipe_end)
);

// File: tb/tb_sym_fir_core.sv
module tb_sym_fir_core;
  localparam int CLK_PERIOD = 10;

  localparam int TA = 7;
  localparam int TB = 6;
  localparam logic [31:0] COEF_A = {8'd40, 8'd0, 8'hFB, 8'd3};
  localparam logic [23:0] COEF_B = {8'd100, 8'd12, 8'hF9};
  localparam int LAT_A = 9;   // (7-1)/2 + 6
  localparam int LAT_B = 7;   // 6/2 + 4

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic signed [7:0]  x_in = '0;
  logic signed [18:0] out_a, out_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  sym_fir_core #(.TAPS(TA), .DW(8), .CW(8), .FW(6), .ANTI_SYM(1'b0),
                 .SKIP_ZERO(1'b1), .COEFS(COEF_A)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .x_in(x_in), .acc_out(out_a));

  sym_fir_core #(.TAPS(TB), .DW(8), .CW(8), .FW(6), .ANTI_SYM(1'b1),
                 .SKIP_ZERO(1'b0), .COEFS(COEF_B)) dut_even (
    .clk(clk), .rst_n(rst_n), .en(en), .x_in(x_in), .acc_out(out_b));

  int compared = 0;
  int mismatched = 0;
  string tag = "R7";

  // behavioural reference: full impulse responses and sample histories
  longint ha [TA];
  longint hb [TB];
  longint xa [TA];
  longint xb [TB];
  longint qa [$];
  longint qb [$];
  longint exp_a = 0, exp_b = 0;

  initial begin
    for (int j = 0; j < TA; j++) begin
      if (j < 4) ha[j] = longint'($signed(COEF_A[j*8 +: 8]));
      else       ha[j] = ha[TA-1-j];
    end
    for (int j = 0; j < TB; j++) begin
      if (j < 3) hb[j] = longint'($signed(COEF_B[j*8 +: 8]));
      else       hb[j] = -hb[TB-1-j];
    end
  end

  task automatic model_clear();
    for (int i = 0; i < TA; i++) xa[i] = 0;
    for (int i = 0; i < TB; i++) xb[i] = 0;
    qa.delete(); qb.delete();
    for (int i = 0; i < LAT_A; i++) qa.push_back(0);
    for (int i = 0; i < LAT_B; i++) qb.push_back(0);
    exp_a = 0; exp_b = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      model_clear();
    end else if (en) begin
      longint ya, yb;
      for (int i = TA-1; i > 0; i--) xa[i] = xa[i-1];
      for (int i = TB-1; i > 0; i--) xb[i] = xb[i-1];
      xa[0] = longint'(x_in);
      xb[0] = longint'(x_in);
      ya = 0; yb = 0;
      for (int i = 0; i < TA; i++) ya += ha[i] * xa[i];
      for (int i = 0; i < TB; i++) yb += hb[i] * xb[i];
      qa.push_back(ya); qb.push_back(yb);
      exp_a = qa.pop_front();
      exp_b = qb.pop_front();
    end
  end

  task automatic compare();
    compared++;
    if (longint'(out_a) != exp_a) begin
      mismatched++;
      $display("FAIL %s odd-tap: got %0d expected %0d", tag, out_a, exp_a);
    end
    compared++;
    if (longint'(out_b) != exp_b) begin
      mismatched++;
      $display("FAIL %s even-tap: got %0d expected %0d", tag, out_b, exp_b);
    end
  endtask

  task automatic step(input logic signed [7:0] x, input logic e);
    @(negedge clk);
    compare();
    x_in = x;
    en = e;
  endtask

  initial begin
    logic signed [18:0] held_a;
    logic signed [18:0] held_b;
    // R7: reset state
    model_clear();
    repeat (3) step(8'sd0, 1'b0);
    rst_n = 1'b1;
    tag = "R7";
    step(8'sd0, 1'b0);

    // R1 R4 R5 R10 (odd) and R2 R3 R5 (even): impulse walks every coefficient into view
    tag = "R1,R2,R3,R4,R5,R10";
    step(8'sd100, 1'b1);
    repeat (16) step(8'sd0, 1'b1);

    // R9: sustained full scale of both signs
    tag = "R9";
    repeat (12) step(8'sd127, 1'b1);
    repeat (12) step(-8'sd128, 1'b1);
    for (int i = 0; i < 24; i++) step((i % 2) ? 8'sd127 : -8'sd128, 1'b1);

    // R6: enable gaps; values presented while idle must not enter
    tag = "R6";
    for (int i = 0; i < 120; i++) step($signed(8'($urandom)), 1'($urandom % 2));
    step(8'sd55, 1'b1);
    step(-8'sd77, 1'b0);
    held_a = out_a; held_b = out_b;
    repeat (5) step($signed(8'($urandom)), 1'b0);
    compared++;
    if (out_a !== held_a || out_b !== held_b) begin
      mismatched++;
      $display("FAIL R6 hold: got %0d/%0d expected %0d/%0d", out_a, out_b, held_a, held_b);
    end

    // R1 R2 R3 R8: dense random stream
    tag = "R1,R2,R3,R8";
    for (int i = 0; i < 200; i++) step($signed(8'($urandom)), 1'b1);

    // R7: reset mid-stream clears history
    tag = "R7";
    rst_n = 1'b0;
    step(8'sd90, 1'b1);
    rst_n = 1'b1;
    step(8'sd0, 1'b0);
    compared++;
    if (out_a !== '0 || out_b !== '0) begin
      mismatched++;
      $display("FAIL R7 clear: got %0d/%0d expected 0/0", out_a, out_b);
    end
    tag = "R5,R7";
    step(-8'sd64, 1'b1);
    repeat (14) step(8'sd0, 1'b1);
    step(8'sd0, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule